// File: doc/BRIEF.md
# Tape DMA Transfer Counter and Address Generator

This block keeps the two running quantities a tape controller needs while it moves data between the drive and memory. The first is a 16-bit transfer counter. The host loads it with the negated (two's-complement) number of bytes or records, and it counts up toward zero. The second is an 18-bit memory pointer, made of a 16-bit word address and a 2-bit upper extension. The pointer steps by two after every successful memory access, so it always points one word past the last location used.

The active mode decides what the counter counts. In the three data-moving modes it counts accepted memory accesses. In the two spacing modes it counts record-boundary check characters, and the pointer is left alone.

From the count state the block derives three signals:
- a data request that answers each write strobe from the drive while bytes remain;
- a sticky record-length error for a read that runs past the end of the buffer;
- a re-issue pulse that starts the next record in a spacing run while records remain.

A bus fault during an access freezes the pointer on the failing location until the host reloads it.

Top module: `xfer_cnt_addr_unit`

## Requirements
- R1: After reset, or a cycle with `init_clr` high, the counter, pointer, fault flag, length error, data request and re-issue pulse are all zero.
- R2: A cycle with `cnt_wr_en` loads `cnt_wr_data` into the counter, and a cycle with `addr_wr_en` loads the full 18-bit `addr_wr_data` into the pointer; both take effect at the next edge. `addr_host` shows the pointer with bit 0 forced to 0, while `dma_addr` shows all 18 bits.
- R3: Mode codes are 1 read, 2 write, 3 write with long gap, 4 space forward, 5 space reverse, and 0, 6, 7 inactive. In a mode of 1 to 3, a cycle with `mem_done` high, `bus_err` low, no held fault and a nonzero counter adds 1 to the counter and 2 to the pointer. A carry out of pointer bit 15 increments bits 17:16.
- R4: `cnt_zero` is high exactly when the counter is 0. Once the counter is 0, neither accesses nor record boundaries change the counter or the pointer.
- R5: In modes 4 and 5, each `lpc_strobe` adds 1 to a nonzero counter in either direction, and `mem_done` has no effect on the pointer.
- R6: In modes 2 and 3, `data_req` pulses high in the cycle after a `wr_strobe` only if the counter was nonzero when the strobe arrived.
- R7: In mode 1, an `rd_strobe` with `chk_strobe` low while the counter is 0 sets `len_err`. The flag stays set until a counter load or `init_clr`. A strobe with `chk_strobe` high never sets it.
- R8: In modes 1 to 3, `mem_done` together with `bus_err` sets `addr_fault` and leaves the pointer on the failing address. While the fault is held, the pointer and counter do not advance. A pointer load clears the fault.
- R9: In modes 4 and 5, a rising edge on `settle` while the counter is nonzero produces a one-cycle `go_again` pulse in the following cycle. No pulse is produced once the counter is 0.
- R10: A host load in the same cycle as an advance event wins, so the loaded value appears unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_clr | input | 1 | Synchronous clear of all state |
| mode | input | 3 | Active operation code |
| cnt_wr_en | input | 1 | Host load strobe for the counter |
| cnt_wr_data | input | 16 | Negated count to load |
| addr_wr_en | input | 1 | Host load strobe for the pointer |
| addr_wr_data | input | 18 | Start address, extension in bits 17:16 |
| mem_done | input | 1 | One memory access finished |
| bus_err | input | 1 | The finishing access faulted (grant late or no memory) |
| rd_strobe | input | 1 | Read data strobe from the drive |
| chk_strobe | input | 1 | Current read strobe carries a check character |
| wr_strobe | input | 1 | Write data strobe from the drive |
| lpc_strobe | input | 1 | Record-boundary check character seen |
| settle | input | 1 | Drive is in its slow-down window |
| cnt_val | output | 16 | Current counter |
| cnt_zero | output | 1 | Counter equals zero |
| addr_host | output | 18 | Pointer as seen by the host, bit 0 reads 0 |
| dma_addr | output | 18 | Full pointer for memory cycles |
| addr_fault | output | 1 | Pointer frozen after a bus fault |
| data_req | output | 1 | Data request answering a write strobe |
| len_err | output | 1 | Sticky record-length error |
| go_again | output | 1 | Pulse starting the next record in a spacing run |

## Verification
The hardest states to reach from the ports combine a held bus fault with later good accesses, and a pointer carry into the extension at the same moment the counter reaches zero. Directed sequences reach both.
- For the carry case, the bench loads a pointer two words below the 64K boundary with a count of minus three, then walks across the boundary.
- For the fault case, it injects a fault mid-record, keeps issuing accesses to confirm the freeze, and then releases the fault with a reload.

A long random phase then mixes modes, strobes, loads near zero and occasional faults. During that phase a behavioural model is compared against every output on every cycle.

// File: rtl/xca_pkg.sv
package xca_pkg;

  typedef enum logic [2:0] {
    XM_IDLE     = 3'd0,
    XM_READ     = 3'd1,
    XM_WRITE    = 3'd2,
    XM_WRITE_LG = 3'd3,
    XM_SPACE_F  = 3'd4,
    XM_SPACE_R  = 3'd5,
    XM_REWIND   = 3'd6,
    XM_OFFLINE  = 3'd7
  } xmode_t;

  function automatic logic mode_moves_data(input logic [2:0] m);
    return (m == XM_READ) || (m == XM_WRITE) || (m == XM_WRITE_LG);
  endfunction

  function automatic logic mode_writes(input logic [2:0] m);
    return (m == XM_WRITE) || (m == XM_WRITE_LG);
  endfunction

  function automatic logic mode_reads(input logic [2:0] m);
    return m == XM_READ;
  endfunction

  function automatic logic mode_spaces(input logic [2:0] m);
    return (m == XM_SPACE_F) || (m == XM_SPACE_R);
  endfunction

endpackage

// File: rtl/xca_counter.sv
module xca_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_clr,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (init_clr)
      cnt <= '0;
    else if (ld_en)
      cnt <= ld_val;
    else if (adv && !zero)
      cnt <= bump(cnt);
  end

endmodule

// File: rtl/xca_addr_gen.sv
module xca_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2,
  localparam int FULL_W = ADDR_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_clr,
  input  logic              ld_en,
  input  logic [FULL_W-1:0] ld_val,
  input  logic              step,
  input  logic              err,
  output logic [FULL_W-1:0] addr,
  output logic              fault
);

  logic [ADDR_W-1:0] base_q;
  logic [EXT_W-1:0]  ext_q;
  logic [ADDR_W:0]   base_sum;
  logic [EXT_W-1:0]  ext_next;

  // word step on the low part, carry rippled into the extension
  function automatic logic [ADDR_W:0] word_step(input logic [ADDR_W-1:0] b);
    return {1'b0, b} + (ADDR_W+1)'(2);
  endfunction

  function automatic logic [EXT_W-1:0] ext_step(input logic [EXT_W-1:0] e,
                                                input logic c);
    return e + EXT_W'(c);
  endfunction

  assign base_sum = word_step(base_q);
  assign ext_next = ext_step(ext_q, base_sum[ADDR_W]);
  assign addr     = {ext_q, base_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ext_q  <= '0;
      fault  <= 1'b0;
    end else if (init_clr) begin
      base_q <= '0;
      ext_q  <= '0;
      fault  <= 1'b0;
    end else if (ld_en) begin
      base_q <= ld_val[ADDR_W-1:0];
      ext_q  <= ld_val[FULL_W-1:ADDR_W];
      fault  <= 1'b0;
    end else if (err) begin
      fault  <= 1'b1;
    end else if (step && !fault) begin
      base_q <= base_sum[ADDR_W-1:0];
      ext_q  <= ext_next;
    end
  end

endmodule

// File: rtl/xca_events.sv
module xca_events
  import xca_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_clr,
  input  logic [2:0] mode,
  input  logic       cnt_zero,
  input  logic       cnt_ld,
  input  logic       rd_strobe,
  input  logic       chk_strobe,
  input  logic       wr_strobe,
  input  logic       settle,
  output logic       data_req,
  output logic       len_err,
  output logic       go_again
);

  logic settle_q;
  logic ev_req;
  logic ev_overrun;
  logic ev_rego;

  assign ev_req     = mode_writes(mode) && wr_strobe && !cnt_zero;
  assign ev_overrun = mode_reads(mode) && rd_strobe && !chk_strobe && cnt_zero;
  assign ev_rego    = mode_spaces(mode) && settle && !settle_q && !cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= 1'b0;
      data_req <= 1'b0;
      len_err  <= 1'b0;
      go_again <= 1'b0;
    end else begin
      settle_q <= settle;
      if (init_clr) begin
        data_req <= 1'b0;
        len_err  <= 1'b0;
        go_again <= 1'b0;
      end else begin
        data_req <= ev_req;
        go_again <= ev_rego;
        if (cnt_ld)
          len_err <= 1'b0;
        else if (ev_overrun)
          len_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/xfer_cnt_addr_unit.sv
module xfer_cnt_addr_unit
  import xca_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2,
  localparam int FULL_W = ADDR_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_clr,
  input  logic [2:0]        mode,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  input  logic              addr_wr_en,
  input  logic [FULL_W-1:0] addr_wr_data,
  input  logic              mem_done,
  input  logic              bus_err,
  input  logic              rd_strobe,
  input  logic              chk_strobe,
  input  logic              wr_strobe,
  input  logic              lpc_strobe,
  input  logic              settle,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              cnt_zero,
  output logic [FULL_W-1:0] addr_host,
  output logic [FULL_W-1:0] dma_addr,
  output logic              addr_fault,
  output logic              data_req,
  output logic              len_err,
  output logic              go_again
);

  // named internal events
  logic ev_access_ok;
  logic ev_access_err;
  logic ev_record;
  logic cnt_adv;

  assign ev_access_ok  = mode_moves_data(mode) && mem_done && !bus_err &&
                         !addr_fault && !cnt_zero;
  assign ev_access_err = mode_moves_data(mode) && mem_done && bus_err;
  assign ev_record     = mode_spaces(mode) && lpc_strobe;
  assign cnt_adv       = ev_access_ok || ev_record;

  xca_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_clr (init_clr),
    .ld_en    (cnt_wr_en),
    .ld_val   (cnt_wr_data),
    .adv      (cnt_adv),
    .cnt      (cnt_val),
    .zero     (cnt_zero)
  );

  xca_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_clr (init_clr),
    .ld_en    (addr_wr_en),
    .ld_val   (addr_wr_data),
    .step     (ev_access_ok),
    .err      (ev_access_err),
    .addr     (dma_addr),
    .fault    (addr_fault)
  );

  xca_events u_ev (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_clr   (init_clr),
    .mode       (mode),
    .cnt_zero   (cnt_zero),
    .cnt_ld     (cnt_wr_en),
    .rd_strobe  (rd_strobe),
    .chk_strobe (chk_strobe),
    .wr_strobe  (wr_strobe),
    .settle     (settle),
    .data_req   (data_req),
    .len_err    (len_err),
    .go_again   (go_again)
  );

  assign addr_host = {dma_addr[FULL_W-1:1], 1'b0};

endmodule

// File: rtl/xca_checks.sv
module xca_checks
  import xca_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        init_clr,
  input logic [2:0]  mode,
  input logic        cnt_wr_en,
  input logic        addr_wr_en,
  input logic        ev_access_ok,
  input logic        cnt_zero,
  input logic [17:0] dma_addr,
  input logic        addr_fault,
  input logic        data_req,
  input logic        len_err,
  input logic        go_again
);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_access_ok && !addr_wr_en && !init_clr |=> dma_addr == $past(dma_addr) + 18'd2);

  assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero && !cnt_wr_en && !init_clr |=> cnt_zero);

  assert_space_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_spaces(mode) && !addr_wr_en && !init_clr |=> $stable(dma_addr));

  assert_req_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> !$past(cnt_zero));

  assert_len_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    len_err && !cnt_wr_en && !init_clr |=> len_err);

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fault && !addr_wr_en && !init_clr |=> $stable(dma_addr) && addr_fault);

  assert_rego_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go_again |=> !go_again);

endmodule

bind xfer_cnt_addr_unit xca_checks u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_clr     (init_clr),
  .mode         (mode),
  .cnt_wr_en    (cnt_wr_en),
  .addr_wr_en   (addr_wr_en),
  .ev_access_ok (ev_access_ok),
  .cnt_zero     (cnt_zero),
  .dma_addr     (dma_addr),
  .addr_fault   (addr_fault),
  .data_req     (data_req),
  .len_err      (len_err),
  .go_again     (go_again)
);

// File: tb/tb_xfer_cnt_addr_unit.sv
module tb_xfer_cnt_addr_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_clr = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        cnt_wr_en = 1'b0;
  logic [15:0] cnt_wr_data = '0;
  logic        addr_wr_en = 1'b0;
  logic [17:0] addr_wr_data = '0;
  logic        mem_done = 1'b0, bus_err = 1'b0, rd_strobe = 1'b0, chk_strobe = 1'b0;
  logic        wr_strobe = 1'b0, lpc_strobe = 1'b0, settle = 1'b0;
  logic [15:0] cnt_val;
  logic        cnt_zero, addr_fault, data_req, len_err, go_again;
  logic [17:0] addr_host, dma_addr;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_cnt_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .mode(mode),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .mem_done(mem_done), .bus_err(bus_err), .rd_strobe(rd_strobe),
    .chk_strobe(chk_strobe), .wr_strobe(wr_strobe), .lpc_strobe(lpc_strobe),
    .settle(settle), .cnt_val(cnt_val), .cnt_zero(cnt_zero),
    .addr_host(addr_host), .dma_addr(dma_addr), .addr_fault(addr_fault),
    .data_req(data_req), .len_err(len_err), .go_again(go_again)
  );

  // behavioural reference model
  int m_cnt, m_addr;
  bit m_fault, m_rle, m_req, m_rego, m_settle_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_addr = 0; m_fault = 0; m_rle = 0;
      m_req = 0; m_rego = 0; m_settle_q = 0;
    end else begin
      bit moves, spaces, writes, good;
      moves  = (mode == 1) || (mode == 2) || (mode == 3);
      spaces = (mode == 4) || (mode == 5);
      writes = (mode == 2) || (mode == 3);
      good   = moves && mem_done && !bus_err && !m_fault && (m_cnt != 0);
      if (init_clr) begin
        m_cnt = 0; m_addr = 0; m_fault = 0; m_rle = 0; m_req = 0; m_rego = 0;
      end else begin
        m_req  = writes && wr_strobe && (m_cnt != 0);
        m_rego = spaces && settle && !m_settle_q && (m_cnt != 0);
        if (cnt_wr_en) m_rle = 0;
        else if (mode == 1 && rd_strobe && !chk_strobe && m_cnt == 0) m_rle = 1;
        if (addr_wr_en) begin
          m_addr = int'(addr_wr_data); m_fault = 0;
        end else if (moves && mem_done && bus_err) begin
          m_fault = 1;
        end else if (good) begin
          m_addr = (m_addr + 2) % 262144;
        end
        if (cnt_wr_en) m_cnt = int'(cnt_wr_data);
        else if ((good || (spaces && lpc_strobe)) && m_cnt != 0)
          m_cnt = (m_cnt + 1) % 65536;
      end
      m_settle_q = settle;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(cnt_val) == m_cnt, "R3 counter vs model", int'(cnt_val), m_cnt);
      check(cnt_zero == (m_cnt == 0), "R4 zero flag vs model", cnt_zero, m_cnt == 0);
      check(int'(dma_addr) == m_addr, "R3 pointer vs model", int'(dma_addr), m_addr);
      check(int'(addr_host) == (m_addr & 32'h3FFFE), "R2 host view vs model",
            int'(addr_host), m_addr & 32'h3FFFE);
      check(addr_fault == m_fault, "R8 fault vs model", addr_fault, m_fault);
      check(len_err == m_rle, "R7 length error vs model", len_err, m_rle);
      check(data_req == m_req, "R6 data request vs model", data_req, m_req);
      check(go_again == m_rego, "R9 re-issue vs model", go_again, m_rego);
    end
  end

  // one clock: inputs already set at a negedge, wait to next negedge, drop pulses
  task automatic tick();
    @(negedge clk);
    cnt_wr_en = 0; addr_wr_en = 0; mem_done = 0; bus_err = 0; rd_strobe = 0;
    chk_strobe = 0; wr_strobe = 0; lpc_strobe = 0; init_clr = 0;
  endtask

  task automatic load(input logic [15:0] c, input logic [17:0] a);
    cnt_wr_en = 1; cnt_wr_data = c; addr_wr_en = 1; addr_wr_data = a; tick();
  endtask

  task automatic access(input bit err);
    mem_done = 1; bus_err = err; tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cnt_val == 0 && dma_addr == 0 && !addr_fault && !len_err, "R1 reset state",
          {cnt_val, dma_addr[15:0]}, 0);

    // R3 carry into extension, R4 stop at zero
    mode = 3'd2;
    load(16'hFFFD, 18'h0FFFC);
    access(0); access(0);
    check(dma_addr == 18'h10000, "R3 carry into bits 17:16", dma_addr, 18'h10000);
    access(0);
    check(cnt_val == 0 && cnt_zero, "R4 counter reaches zero", cnt_val, 0);
    check(dma_addr == 18'h10002, "R3 pointer after record", dma_addr, 18'h10002);
    access(0);
    check(cnt_val == 0 && dma_addr == 18'h10002, "R4 no advance at zero", dma_addr, 18'h10002);

    // R6 data request only while count remains
    wr_strobe = 1; tick();
    check(data_req == 0, "R6 no request at zero", data_req, 0);
    cnt_wr_en = 1; cnt_wr_data = 16'hFFFF; tick();
    wr_strobe = 1; tick();
    check(data_req == 1, "R6 request with count left", data_req, 1);
    tick();
    check(data_req == 0, "R6 request is one cycle", data_req, 0);

    // R7 length error in read
    mode = 3'd1;
    cnt_wr_en = 1; cnt_wr_data = 16'h0000; tick();
    rd_strobe = 1; chk_strobe = 1; tick();
    check(len_err == 0, "R7 check strobe ignored", len_err, 0);
    rd_strobe = 1; tick();
    check(len_err == 1, "R7 overrun sets error", len_err, 1);
    tick(); tick();
    check(len_err == 1, "R7 error sticky", len_err, 1);
    cnt_wr_en = 1; cnt_wr_data = 16'hFFF0; tick();
    check(len_err == 0, "R7 counter load clears", len_err, 0);

    // R8 bus fault freeze
    addr_wr_en = 1; addr_wr_data = 18'h00100; tick();
    access(0);
    access(1);
    check(addr_fault == 1 && dma_addr == 18'h00102, "R8 pointer kept on failure", dma_addr, 18'h00102);
    access(0); access(0);
    check(dma_addr == 18'h00102 && cnt_val == 16'hFFF1, "R8 frozen while held",
          {cnt_val, dma_addr[15:0]}, {16'hFFF1, 16'h0102});
    addr_wr_en = 1; addr_wr_data = 18'h00201; tick();
    check(addr_fault == 0, "R8 reload clears fault", addr_fault, 0);
    // R2 host view masks bit 0
    check(addr_host == 18'h00200 && dma_addr == 18'h00201, "R2 bit 0 masked for host",
          addr_host, 18'h00200);

    // R5 space modes, R9 re-issue
    mode = 3'd4;
    cnt_wr_en = 1; cnt_wr_data = 16'hFFFE; tick();
    access(0);
    check(dma_addr == 18'h00201, "R5 access ignored in space", dma_addr, 18'h00201);
    settle = 1; tick();
    check(go_again == 1, "R9 re-issue with records left", go_again, 1);
    tick();
    check(go_again == 0, "R9 pulse lasts one cycle", go_again, 0);
    settle = 0; lpc_strobe = 1; tick();
    mode = 3'd5; lpc_strobe = 1; tick();
    check(cnt_zero == 1, "R5 reverse record counted", cnt_val, 0);
    settle = 1; tick();
    check(go_again == 0, "R9 no re-issue at zero", go_again, 1'b0);
    settle = 0;

    // R10 load wins over advance
    mode = 3'd3;
    cnt_wr_en = 1; cnt_wr_data = 16'hFF00; tick();
    cnt_wr_en = 1; cnt_wr_data = 16'h1234; mem_done = 1; tick();
    check(cnt_val == 16'h1234, "R10 load beats access", cnt_val, 16'h1234);

    // R1 synchronous clear
    init_clr = 1; tick();
    check(cnt_val == 0 && dma_addr == 0 && !data_req, "R1 init clears", dma_addr, 0);

    // random phase, compared against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      mode       = 3'($urandom_range(0, 7));
      mem_done   = ($urandom_range(0, 2) == 0);
      bus_err    = ($urandom_range(0, 40) == 0);
      rd_strobe  = ($urandom_range(0, 2) == 0);
      chk_strobe = ($urandom_range(0, 3) == 0);
      wr_strobe  = ($urandom_range(0, 2) == 0);
      lpc_strobe = ($urandom_range(0, 3) == 0);
      settle     = ($urandom_range(0, 3) == 0);
      cnt_wr_en  = ($urandom_range(0, 15) == 0);
      cnt_wr_data = 16'hFFF8 | 16'($urandom_range(0, 7));
      addr_wr_en = ($urandom_range(0, 30) == 0);
      addr_wr_data = 18'($urandom);
      init_clr   = ($urandom_range(0, 300) == 0);
      tick();
    end
    settle = 0;
    tick();
    summary();
  end

endmodule